// File: doc/BRIEF.md
# Low-Power Mode Sequencer for an 8-bit Controller Core

This block decides when the processor core of a small 8-bit controller may run and when it must sleep. Software asks for a sleep state by writing the power-control register. Bit 0 asks for the light sleep state (idle) and bit 1 asks for the deep sleep state (power-down). The block records the request. It changes state on the next machine-cycle tick, which is the boundary where the requesting instruction finishes. After that tick the core clock enable drops, so that instruction is the last one to complete.

In idle, the interrupt, timer and serial logic stay clocked through a separate peripheral enable. Any enabled pending interrupt returns the core to run, clears the idle request in hardware and gives a one-cycle wake pulse. In power-down both enables are off and only a qualified reset leaves the state. The block also overrides the external bus strobes: both are held high in idle and low in power-down.

The reset pin is active high. It is only accepted after it has stayed high for two machine cycles of oscillator clocks. The accepted reset is given out to the chip and also clears both sleep requests.

Top module: `lpm_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, cpu_clk_en=1, per_clk_en=1, strobe_force=0, ale_level=0, psen_level=0, wake=0 and sys_rst=0.
- R2: A register write alone does not change any output. The state changes at the clock edge that samples mc_tick=1 while a request is held, and the outputs show the new state in the following cycle.
- R3: In idle the outputs are cpu_clk_en=0, per_clk_en=1, strobe_force=1, ale_level=1 and psen_level=1.
- R4: In power-down the outputs are cpu_clk_en=0, per_clk_en=0, strobe_force=1, ale_level=0 and psen_level=0. per_clk_en is never low while cpu_clk_en is high.
- R5: A single write with both bit 0 and bit 1 set leads to power-down, not idle.
- R6: In idle, irq_pend=1 at a clock edge returns the core to run at that edge. wake is high for exactly that following cycle, and the idle request is cleared, so a later mc_tick leaves the core running.
- R7: In power-down, irq_pend has no effect on any output.
- R8: sys_rst rises after the rst_pin=1 level has been sampled at 24 consecutive clock edges (2 machine cycles of 12 clocks). A high pulse seen at only 23 edges gives no sys_rst. sys_rst falls at the first edge that samples rst_pin=0.
- R9: A qualified reset returns the core to run from idle or from power-down and clears both pending requests.
- R10: In run, irq_pend gives no wake. A write of 0 to both bits withdraws an earlier request, so the next mc_tick keeps the core running.
- R11: Register writes made while in idle or in power-down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pcon_we | input | 1 | Write strobe of the power-control register |
| pcon_wdata | input | 8 | Write data; bit 0 requests idle, bit 1 requests power-down |
| mc_tick | input | 1 | One-clock pulse at each machine-cycle boundary |
| irq_pend | input | 1 | An enabled interrupt is pending |
| rst_pin | input | 1 | External reset level, already synchronous to clk |
| cpu_clk_en | output | 1 | Clock enable for the core |
| per_clk_en | output | 1 | Clock enable for interrupt, timer and serial logic |
| strobe_force | output | 1 | Bus strobes are overridden by the two level outputs |
| ale_level | output | 1 | Forced address-latch strobe level |
| psen_level | output | 1 | Forced program-fetch strobe level |
| wake | output | 1 | One-cycle pulse on interrupt wake from idle |
| sys_rst | output | 1 | Qualified internal reset |

## Verification
Mode changes, wake pulses and strobe levels appear one clock after the edge that samples the tick or the interrupt. A write request never shows up on its own; it needs a later tick edge. sys_rst follows the 24th consecutive high sample of the pin, and it is one further clock before the mode outputs show the return to run. The bench drives inputs on the falling edge and reads outputs on the next falling edge. For the reset pin it checks sys_rst after every single edge of the high window, so an early or late assertion is seen.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2
  } lpm_state_e;
endpackage

// File: rtl/lpm_rst_qual.sv
// Accepts the reset pin only after a run of consecutive high samples.
module lpm_rst_qual #(
  parameter int QUAL_CLKS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic valid_o
);
  localparam int CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else if (!pin_i) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      valid_o <= (cnt_q == LAST);
    end
  end

  // R8
  drop_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_i |=> !valid_o);

  // R8
  rise_needs_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(pin_i));
endmodule

// File: rtl/lpm_mode_fsm.sv
// Run / idle / power-down sequencing with pending requests.
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic       req_idle_i,
  input  logic       req_pd_i,
  input  logic       tick_i,
  input  logic       irq_i,
  output lpm_state_e state_o,
  output logic       wake_o
);
  lpm_state_e state_q;
  logic       idle_q, pd_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      state_q <= ST_RUN;
      idle_q  <= 1'b0;
      pd_q    <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (we_i) begin
            idle_q <= req_idle_i;
            pd_q   <= req_pd_i;
          end else if (tick_i) begin
            if (pd_q)        state_q <= ST_PDOWN;
            else if (idle_q) state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (irq_i) begin
            state_q <= ST_RUN;
            idle_q  <= 1'b0;
            wake_o  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;

  // R2
  entry_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_RUN && state_q != ST_RUN) |-> $past(tick_i));

  // R7
  pd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PDOWN && !clr_i) |=> (state_q == ST_PDOWN));

  // R6
  wake_source_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ($past(state_q) == ST_IDLE && $past(irq_i)));
endmodule

// File: rtl/lpm_out_map.sv
// Decodes the mode into clock enables and strobe overrides.
module lpm_out_map
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  output logic       cpu_en_o,
  output logic       per_en_o,
  output logic       force_o,
  output logic       ale_o,
  output logic       psen_o
);
  always_comb begin
    cpu_en_o = (state_i == ST_RUN);
    per_en_o = (state_i != ST_PDOWN);
    force_o  = (state_i != ST_RUN);
    ale_o    = (state_i == ST_IDLE);
    psen_o   = (state_i == ST_IDLE);
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDLE_BIT    = 0,
  parameter int PD_BIT      = 1,
  parameter int CLKS_PER_MC = 12,
  parameter int QUAL_MC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pcon_we,
  input  logic [DATA_W-1:0] pcon_wdata,
  input  logic              mc_tick,
  input  logic              irq_pend,
  input  logic              rst_pin,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              strobe_force,
  output logic              ale_level,
  output logic              psen_level,
  output logic              wake,
  output logic              sys_rst
);
  localparam int QUAL_CLKS = CLKS_PER_MC * QUAL_MC;

  lpm_state_e state;

  lpm_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (rst_pin),
    .valid_o(sys_rst)
  );

  lpm_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (sys_rst),
    .we_i      (pcon_we),
    .req_idle_i(pcon_wdata[IDLE_BIT]),
    .req_pd_i  (pcon_wdata[PD_BIT]),
    .tick_i    (mc_tick),
    .irq_i     (irq_pend),
    .state_o   (state),
    .wake_o    (wake)
  );

  lpm_out_map u_map (
    .state_i (state),
    .cpu_en_o(cpu_clk_en),
    .per_en_o(per_clk_en),
    .force_o (strobe_force),
    .ale_o   (ale_level),
    .psen_o  (psen_level)
  );

  // R4
  gate_order_chk: assert property (@(posedge clk) disable iff (rst)
    !per_clk_en |-> !cpu_clk_en);

  // R9
  reset_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> cpu_clk_en);
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       pcon_we;
  logic [7:0] pcon_wdata;
  logic       mc_tick, irq_pend, rst_pin;
  logic       cpu_clk_en, per_clk_en, strobe_force, ale_level, psen_level;
  logic       wake, sys_rst;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl dut (
    .clk(clk), .rst(rst), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
    .mc_tick(mc_tick), .irq_pend(irq_pend), .rst_pin(rst_pin),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .strobe_force(strobe_force), .ale_level(ale_level),
    .psen_level(psen_level), .wake(wake), .sys_rst(sys_rst)
  );

  // Vector: [11]we [10]bit1 [9]bit0 [8]tick [7]irq [6]pin |
  //         [5]cpu [4]per [3]force [2]ale [1]psen [0]wake
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    12'b0_00_0_1_0_110000,  // R10 irq in run, no wake
    12'b1_01_0_0_0_110000,  // R2 request idle, no change
    12'b1_00_0_0_0_110000,  // R10 withdraw request
    12'b0_00_1_0_0_110000,  // R10 tick stays run
    12'b1_01_0_0_0_110000,  // R2 request idle
    12'b0_00_1_0_0_011110,  // R3 idle entered
    12'b0_00_1_0_0_011110,  // R3 stays idle
    12'b1_10_0_0_0_011110,  // R11 write in idle ignored
    12'b0_00_0_1_0_110001,  // R6 wake
    12'b0_00_0_0_0_110000,  // R6 pulse ends
    12'b0_00_1_0_0_110000,  // R6 idle bit cleared, R11 pd not latched
    12'b1_10_0_0_0_110000,  // R2 request power-down
    12'b0_00_1_0_0_001000,  // R4 power-down entered
    12'b0_00_0_1_0_001000,  // R7 irq ignored
    12'b1_01_0_0_0_001000,  // R11 write in power-down ignored
    12'b0_00_1_0_0_001000   // R7 still power-down
  };
  localparam int VREQ [NV] = '{10,2,10,10,2,3,3,11,6,6,6,2,4,7,11,7};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {cpu_clk_en, per_clk_en, strobe_force, ale_level, psen_level, wake};
  endfunction

  task automatic idle_inputs();
    pcon_we = 1'b0; pcon_wdata = 8'h00; mc_tick = 1'b0; irq_pend = 1'b0;
  endtask

  task automatic write_pcon(input logic [7:0] d);
    pcon_we = 1'b1; pcon_wdata = d; step(); idle_inputs();
  endtask

  task automatic tick();
    mc_tick = 1'b1; step(); mc_tick = 1'b0;
  endtask

  task automatic pin_high(input int edges);
    rst_pin = 1'b1;
    for (int k = 0; k < edges; k++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rst_pin = 1'b0; idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", outs(), 6'b110000);
    chk("R1 sys_rst", {5'b0, sys_rst}, 6'b0);

    for (int i = 0; i < NV; i++) begin
      pcon_we = VEC[i][11]; pcon_wdata = {6'b0, VEC[i][10:9]};
      mc_tick = VEC[i][8]; irq_pend = VEC[i][7]; rst_pin = VEC[i][6];
      step();
      chk($sformatf("R%0d vec %0d", VREQ[i], i), outs(), VEC[i][5:0]);
    end
    idle_inputs();

    // R8: a 23-edge pulse is rejected; core stays in power-down
    rst_pin = 1'b1;
    for (int k = 0; k < 23; k++) begin
      step();
      chk("R8 short", {5'b0, sys_rst}, 6'b0);
    end
    rst_pin = 1'b0; step();
    chk("R8 short", {5'b0, sys_rst}, 6'b0);
    chk("R7 still pd", outs(), 6'b001000);

    // R8: qualification exactly at the 24th edge
    rst_pin = 1'b1;
    for (int k = 0; k < 23; k++) begin
      step();
      chk("R8 early", {5'b0, sys_rst}, 6'b0);
    end
    step();
    chk("R8 rise", {5'b0, sys_rst}, 6'b1);
    step();
    chk("R9 from pd", outs(), 6'b110000);
    rst_pin = 1'b0; step();
    chk("R8 fall", {5'b0, sys_rst}, 6'b0);

    // R9: reset from idle clears the pending idle request
    write_pcon(8'h01); tick();
    chk("R9 idle set", outs(), 6'b011110);
    pin_high(25); rst_pin = 1'b0; step();
    chk("R9 from idle", outs(), 6'b110000);
    tick();
    chk("R9 req cleared", outs(), 6'b110000);

    // R9: pending power-down request dropped by reset
    write_pcon(8'h02);
    pin_high(25); rst_pin = 1'b0; step();
    tick();
    chk("R9 pd cleared", outs(), 6'b110000);

    // R5: both bits written together
    write_pcon(8'h03);
    chk("R5 no change", outs(), 6'b110000);
    tick();
    chk("R5 pd wins", outs(), 6'b001000);

    // R1: synchronous reset from power-down
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 again", outs(), 6'b110000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule